// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers fourteen interrupt request lines and latches each rising request into a sticky pending flag. A per-source class bit assigns every line either to the fast class or to the normal class. A per-source enable bit decides whether a pending flag may raise a request toward the processor. Each cycle the block offers the processor at most one request, on a fast line or on a normal line, together with the index of the winning source.

The processor accepts the offered request with a `take` strobe and ends a service with one return strobe per class. The block keeps track of the nesting. A fast request may interrupt a normal service. A fast service cannot be interrupted. One normal service never interrupts another. Software clears pending flags by writing ones to a clear mask.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A one-cycle high on `req_pulse[i]` sets `pend_flags[i]` after the next clock edge. The flag stays set until it is cleared, and it does not depend on the level of the request line afterwards.
- R2: When `clr_we` is high, each bit set in `clr_mask` clears the matching pending flag. A request and a clear of the same bit in the same cycle leave the flag set. When `clr_we` is low, `clr_mask` has no effect.
- R3: A source whose `src_en` bit is 0 still records its pending flag. It never drives `fast_irq` or `norm_irq`, and it is never reported on `win_idx`.
- R4: `src_fast[i]`=1 places source i in the fast class and 0 places it in the normal class. When sources of both classes are eligible in the idle state, only `fast_irq` is raised, and `win_idx` names the fast source. The two request lines are never high together.
- R5: Within a class, the eligible source with the lowest number wins. `win_idx` is 0 whenever neither request line is high.
- R6: A `take` strobe while `fast_irq` is high starts a fast service (`in_fast`=1). If a normal service was active, the fast service nests on top of it and `in_norm` stays 1. A `take` strobe while `norm_irq` is high starts a normal service (`in_norm`=1).
- R7: During a normal service with no fast service, `norm_irq` stays low and new normal requests remain pending. Eligible fast requests still raise `fast_irq`.
- R8: During a fast service, neither `fast_irq` nor `norm_irq` is raised, whatever is pending.
- R9: `ret_fast` ends a fast service and returns the block to the normal service if one was nested, or to idle otherwise. `ret_norm` ends a normal service only when no fast service is active. A return strobe with no matching active service is ignored.
- R10: A `take` strobe while neither request line is high changes nothing. In a cycle with a valid return strobe, `take` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pulse | input | 14 | Raw request pulses, one per source |
| src_en | input | 14 | Per-source request enable |
| src_fast | input | 14 | Per-source class select, 1 = fast, 0 = normal |
| clr_we | input | 1 | Write strobe for the pending clear mask |
| clr_mask | input | 14 | Write-one-to-clear mask for pending flags |
| take | input | 1 | Processor accepts the offered request |
| ret_fast | input | 1 | Return from fast service |
| ret_norm | input | 1 | Return from normal service |
| fast_irq | output | 1 | Fast-class request to the processor |
| norm_irq | output | 1 | Normal-class request to the processor |
| win_idx | output | 4 | Index of the winning source |
| pend_flags | output | 14 | Current pending flags |
| in_fast | output | 1 | A fast service is active |
| in_norm | output | 1 | A normal service is active, possibly under a fast one |

## Verification
The assertions check the following on every cycle:
- the request lines are never high together;
- the winner is pending, enabled, in the right class and the lowest-numbered eligible source;
- no request is raised during a fast service, and no normal request during a normal service;
- pending flags set and clear as the request and clear strobes demand;
- a fast entry nests over a normal service, and a fast return restores the earlier normal state.

Only the directed scenarios show the following:
- that a masked flag shows up once it is enabled;
- that fast requests still win during a normal service;
- that stray returns and takes with nothing offered are ignored;
- that the full sequence of a nested service leads back to idle with the correct winner.

// File: rtl/nic_pkg.sv
package nic_pkg;

  typedef enum logic [1:0] {
    NS_IDLE = 2'd0,
    NS_NORM = 2'd1,
    NS_FAST = 2'd2,
    NS_NEST = 2'd3
  } nest_st_t;

  // a fast request may be offered while idle or inside a normal service
  function automatic logic fast_allowed(input nest_st_t st);
    return (st == NS_IDLE) || (st == NS_NORM);
  endfunction

  // a normal request may be offered only while idle
  function automatic logic norm_allowed(input nest_st_t st);
    return st == NS_IDLE;
  endfunction

  function automatic logic st_fast(input nest_st_t st);
    return (st == NS_FAST) || (st == NS_NEST);
  endfunction

  function automatic logic st_norm(input nest_st_t st);
    return (st == NS_NORM) || (st == NS_NEST);
  endfunction

endpackage

// File: rtl/nic_pend_bank.sv
module nic_pend_bank #(
  parameter int N_SRC = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_pulse,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] pend_q
);

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_flag
    logic clr_hit;
    assign clr_hit = clr_we & clr_mask[gi];
    // a new request beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[gi] <= 1'b0;
      else        pend_q[gi] <= req_pulse[gi] | (pend_q[gi] & ~clr_hit);
    end
  end

endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
  parameter int N_SRC = 14,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign any = |cand;
  assign idx = lowest_set(cand);

endmodule

// File: rtl/nic_nest_fsm.sv
module nic_nest_fsm
  import nic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fast_irq,
  input  logic     norm_irq,
  input  logic     take,
  input  logic     ret_fast,
  input  logic     ret_norm,
  output nest_st_t st_q,
  output logic     fast_ret_ev,
  output logic     norm_ret_ev,
  output logic     fast_take_ev,
  output logic     norm_take_ev
);

  nest_st_t st_d;

  // named events: valid returns first, then accepted requests
  assign fast_ret_ev  = ret_fast & st_fast(st_q);
  assign norm_ret_ev  = ret_norm & (st_q == NS_NORM);
  assign fast_take_ev = take & fast_irq & ~fast_ret_ev & ~norm_ret_ev;
  assign norm_take_ev = take & norm_irq & ~fast_irq & ~fast_ret_ev & ~norm_ret_ev;

  always_comb begin
    st_d = st_q;
    if (fast_ret_ev) begin
      st_d = (st_q == NS_NEST) ? NS_NORM : NS_IDLE;
    end else if (norm_ret_ev) begin
      st_d = NS_IDLE;
    end else if (fast_take_ev) begin
      st_d = (st_q == NS_NORM) ? NS_NEST : NS_FAST;
    end else if (norm_take_ev) begin
      st_d = NS_NORM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= NS_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC = 14,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_pulse,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_fast,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic             take,
  input  logic             ret_fast,
  input  logic             ret_norm,
  output logic             fast_irq,
  output logic             norm_irq,
  output logic [IDX_W-1:0] win_idx,
  output logic [N_SRC-1:0] pend_flags,
  output logic             in_fast,
  output logic             in_norm
);

  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] fast_cand;
  logic [N_SRC-1:0] norm_cand;
  logic             fast_any, norm_any;
  logic [IDX_W-1:0] fast_idx, norm_idx;
  nest_st_t         st_q;
  logic             fast_ret_ev, norm_ret_ev, fast_take_ev, norm_take_ev;

  nic_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_pulse(req_pulse),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .pend_q   (pend_q)
  );

  assign elig      = pend_q & src_en;
  assign fast_cand = elig & src_fast;
  assign norm_cand = elig & ~src_fast;

  nic_pick #(.N_SRC(N_SRC)) u_pick_fast (
    .cand(fast_cand),
    .any (fast_any),
    .idx (fast_idx)
  );

  nic_pick #(.N_SRC(N_SRC)) u_pick_norm (
    .cand(norm_cand),
    .any (norm_any),
    .idx (norm_idx)
  );

  nic_nest_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_irq    (fast_irq),
    .norm_irq    (norm_irq),
    .take        (take),
    .ret_fast    (ret_fast),
    .ret_norm    (ret_norm),
    .st_q        (st_q),
    .fast_ret_ev (fast_ret_ev),
    .norm_ret_ev (norm_ret_ev),
    .fast_take_ev(fast_take_ev),
    .norm_take_ev(norm_take_ev)
  );

  assign fast_irq   = fast_any & fast_allowed(st_q);
  assign norm_irq   = norm_any & ~fast_any & norm_allowed(st_q);
  assign win_idx    = fast_irq ? fast_idx : (norm_irq ? norm_idx : '0);
  assign pend_flags = pend_q;
  assign in_fast    = st_fast(st_q);
  assign in_norm    = st_norm(st_q);

endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int N_SRC = 14,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_pulse,
  input logic [N_SRC-1:0] src_en,
  input logic [N_SRC-1:0] src_fast,
  input logic             clr_we,
  input logic [N_SRC-1:0] clr_mask,
  input logic             take,
  input logic             ret_fast,
  input logic             ret_norm,
  input logic             fast_irq,
  input logic             norm_irq,
  input logic [IDX_W-1:0] win_idx,
  input logic [N_SRC-1:0] pend_flags,
  input logic             in_fast,
  input logic             in_norm
);

  logic [N_SRC-1:0] below;
  logic [N_SRC-1:0] class_sel;
  assign below     = (N_SRC'(1) << win_idx) - N_SRC'(1);
  assign class_sel = fast_irq ? src_fast : ~src_fast;

  // R1
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_pulse) |=> ((pend_flags & $past(req_pulse)) == $past(req_pulse)));

  // R2
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_flags & $past(clr_mask & ~req_pulse)) == '0));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_irq || norm_irq) |-> (src_en[win_idx] && pend_flags[win_idx]));

  // R4
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_irq && norm_irq));

  // R5
  win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_irq || norm_irq) |->
      (class_sel[win_idx] && ((pend_flags & src_en & class_sel & below) == '0)));

  // R5
  win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_irq || norm_irq) |-> (win_idx == '0));

  // R6
  nest_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fast_irq && in_norm && !ret_fast && !ret_norm) |=> (in_fast && in_norm));

  // R7
  norm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_norm |-> !norm_irq);

  // R8
  fast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fast |-> !(fast_irq || norm_irq));

  // R9
  fast_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fast && in_fast) |=> (!in_fast && (in_norm == $past(in_norm))));

  // R10
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fast_irq && !norm_irq && !in_fast && !in_norm) |=> (!in_fast && !in_norm));

endmodule

bind nest_irq_ctrl nic_chk #(.N_SRC(N_SRC)) u_nic_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_pulse (req_pulse),
  .src_en    (src_en),
  .src_fast  (src_fast),
  .clr_we    (clr_we),
  .clr_mask  (clr_mask),
  .take      (take),
  .ret_fast  (ret_fast),
  .ret_norm  (ret_norm),
  .fast_irq  (fast_irq),
  .norm_irq  (norm_irq),
  .win_idx   (win_idx),
  .pend_flags(pend_flags),
  .in_fast   (in_fast),
  .in_norm   (in_norm)
);

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;

  localparam int N = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_pulse = '0;
  logic [N-1:0] src_en = '0;
  logic [N-1:0] src_fast = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] clr_mask = '0;
  logic         take = 1'b0;
  logic         ret_fast = 1'b0;
  logic         ret_norm = 1'b0;
  logic         fast_irq, norm_irq, in_fast, in_norm;
  logic [3:0]   win_idx;
  logic [N-1:0] pend_flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .src_en(src_en),
    .src_fast(src_fast), .clr_we(clr_we), .clr_mask(clr_mask), .take(take),
    .ret_fast(ret_fast), .ret_norm(ret_norm), .fast_irq(fast_irq),
    .norm_irq(norm_irq), .win_idx(win_idx), .pend_flags(pend_flags),
    .in_fast(in_fast), .in_norm(in_norm)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge, then drop every strobe; outputs are read 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
    req_pulse = '0;
    clr_we = 1'b0;
    clr_mask = '0;
    take = 1'b0;
    ret_fast = 1'b0;
    ret_norm = 1'b0;
  endtask

  task automatic pulse(input int src);
    req_pulse = '0;
    req_pulse[src] = 1'b1;
    step();
  endtask

  task automatic cleanup();
    clr_we = 1'b1; clr_mask = '1; ret_fast = 1'b1; step();
    ret_norm = 1'b1; step();
    src_en = '1; src_fast = '0;
  endtask

  task automatic t_reset();
    check("R1 reset pend", 32'(pend_flags), 0);
    check("R5 reset irq", {30'd0, fast_irq, norm_irq}, 0);
    check("R9 reset state", {30'd0, in_fast, in_norm}, 0);
  endtask

  task automatic t_sticky();
    src_en = '1; src_fast = '0;
    pulse(5);
    check("R1 flag set", 32'(pend_flags), 32'h20);
    repeat (3) step();
    check("R1 flag held", 32'(pend_flags), 32'h20);
    check("R1 norm req idx", {27'd0, norm_irq, win_idx}, {27'd0, 1'b1, 4'd5});
    cleanup();
  endtask

  task automatic t_w1c();
    src_en = '1; src_fast = '0;
    req_pulse = 14'h0028; step();
    clr_mask = 14'h0020; step();          // no write strobe
    check("R2 mask without strobe", 32'(pend_flags), 32'h28);
    clr_we = 1'b1; clr_mask = 14'h0020; step();
    check("R2 clear bit5", 32'(pend_flags), 32'h08);
    req_pulse[3] = 1'b1; clr_we = 1'b1; clr_mask = 14'h0008; step();
    check("R2 set beats clear", 32'(pend_flags), 32'h08);
    clr_we = 1'b1; clr_mask = 14'h0008; step();
    check("R2 clear all", {pend_flags, norm_irq}, 0);
    cleanup();
  endtask

  task automatic t_mask();
    src_en = '1; src_en[7] = 1'b0; src_fast = '0; src_fast[7] = 1'b1;
    pulse(7);
    check("R3 masked pend", 32'(pend_flags), 32'h80);
    check("R3 masked quiet", {27'd0, fast_irq, norm_irq, win_idx[2:0]}, 0);
    src_en[7] = 1'b1; #1;
    check("R3 enabled raises", {27'd0, fast_irq, win_idx}, {27'd0, 1'b1, 4'd7});
    cleanup();
  endtask

  task automatic t_class();
    src_en = '1; src_fast = '0; src_fast[9] = 1'b1;
    req_pulse[2] = 1'b1; req_pulse[9] = 1'b1; step();
    check("R4 fast over normal", {26'd0, fast_irq, norm_irq, win_idx},
          {26'd0, 1'b1, 1'b0, 4'd9});
    clr_we = 1'b1; clr_mask = 14'h0200; step();
    check("R4 normal after fast cleared", {26'd0, fast_irq, norm_irq, win_idx},
          {26'd0, 1'b0, 1'b1, 4'd2});
    cleanup();
  endtask

  task automatic t_lowest();
    src_en = '1; src_fast = 14'h2400;    // sources 13 and 10 fast
    req_pulse = 14'h1110; step();         // normal 12, 8, 4
    check("R5 lowest normal", {27'd0, norm_irq, win_idx}, {27'd0, 1'b1, 4'd4});
    req_pulse = 14'h2400; step();
    check("R5 lowest fast", {27'd0, fast_irq, win_idx}, {27'd0, 1'b1, 4'd10});
    cleanup();
  endtask

  task automatic t_nest();
    src_en = '1; src_fast = '0; src_fast[11] = 1'b1;
    pulse(4);
    take = 1'b1; step();
    check("R6 normal entry", {30'd0, in_fast, in_norm}, 32'd1);
    pulse(1);
    check("R7 normal held", {30'd0, norm_irq, pend_flags[1]}, 32'd1);
    pulse(11);
    check("R7 fast still offered", {27'd0, fast_irq, win_idx}, {27'd0, 1'b1, 4'd11});
    take = 1'b1; step();
    check("R6 nested entry", {30'd0, in_fast, in_norm}, 32'd3);
    ret_norm = 1'b1; step();
    check("R9 ret_norm ignored while nested", {30'd0, in_fast, in_norm}, 32'd3);
    ret_fast = 1'b1; step();
    check("R9 back to normal", {29'd0, in_fast, in_norm, fast_irq}, 32'd3);
    clr_we = 1'b1; clr_mask = 14'h0800; ret_norm = 1'b1; step();
    check("R9 back to idle", {26'd0, in_fast, in_norm, win_idx}, 32'd1);
    check("R9 normal offered", {31'd0, norm_irq}, 32'd1);
    cleanup();
  endtask

  task automatic t_fast_block();
    src_en = '1; src_fast = 14'h0041;    // sources 0 and 6 fast
    pulse(6);
    take = 1'b1; step();
    check("R6 fast entry", {30'd0, in_fast, in_norm}, 32'd2);
    req_pulse[0] = 1'b1; req_pulse[2] = 1'b1; step();
    check("R8 nothing offered", {30'd0, fast_irq, norm_irq}, 0);
    ret_norm = 1'b1; step();
    check("R9 stray ret_norm", {30'd0, in_fast, in_norm}, 32'd2);
    ret_fast = 1'b1; step();
    check("R9 fast return idle", {26'd0, in_fast, in_norm, fast_irq, win_idx[2:0]},
          {26'd0, 1'b0, 1'b0, 1'b1, 3'd0});
    cleanup();
  endtask

  task automatic t_take_idle();
    src_en = '1; src_fast = '0;
    take = 1'b1; step();
    check("R10 take with nothing", {30'd0, in_fast, in_norm}, 0);
    pulse(3);
    take = 1'b1; ret_fast = 1'b1; step();
    check("R10 take with stray return", {30'd0, in_fast, in_norm}, 32'd1);
    take = 1'b1; req_pulse[9] = 1'b1; src_fast[9] = 1'b1; step();
    check("R10 fast offered", {31'd0, fast_irq}, 32'd1);
    take = 1'b1; ret_norm = 1'b1; step();
    check("R10 take ignored on return", {30'd0, in_fast, in_norm}, 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_sticky();
    t_w1c();
    t_mask();
    t_class();
    t_lowest();
    t_nest();
    t_fast_block();
    t_take_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule